// File: doc/BRIEF.md
# ALU Operand/Result Handshake Manager

This block takes charge of one arithmetic operation from the moment it is issued until its result has been accepted for writeback. At issue it captures the opcode, the operand-modifier flags and an optional immediate. It then asks for each source operand through its own release/go handshake on that operand port. A port is not asked for at all when its operand is replaced by zero or by the immediate, or when the port is masked. Once every needed operand has arrived, a 16-bit combinational adder computes the result. The unit then raises a write release on its single result port and holds the result there until a write go is returned.

Busy stays high from the cycle after issue until the cycle after the write go. A scheduler therefore sees the unit as occupied for the whole life of the operation, and no result is ever dropped. Operand go strobes may be driven combinationally from the matching release. The operand on the port is taken in the same cycle, and the last one is forwarded straight into the adder.

Top module: `alu_op_manager`

## Requirements
- R1: While reset is held and in the first cycle after it is released, busyOut, rdRelOut and wrRelOut are 0 and resultOut is 0.
- R2: An issue is accepted only in a cycle where busyOut is low, and busyOut is high from the next cycle until the cycle after the write go. An issueIn pulse while busyOut is high is ignored and does not change the running operation's result.
- R3: opcodeIn, invertAIn, zeroAIn, immIn and immValidIn are sampled only in the issue cycle. Changing them afterwards has no effect on the result. rdMaskIn is sampled at issue and is held stable by the user while busy.
- R4: Each unsuppressed read port raises its rdRelOut bit in the cycle after issue. The bit stays high through any number of stall cycles until that port's go arrives.
- R5: A go on port i (bit i of rdGoIn, port 0 = operand A, port 1 = operand B) while its release is high drops that release in the next cycle. The release does not rise again before the next issue. A go while the release is low is ignored.
- R6: Port 0 raises no release when zeroAIn or rdMaskIn[0] is set, and operand A is then 0. Port 1 raises no release when immValidIn or rdMaskIn[1] is set. Operand B is then the immediate if immValidIn is set, and 0 otherwise.
- R7: The operand on a port (srcAIn for port 0, srcBIn for port 1) is taken in the cycle in which that port's go meets its high release. Values on the port in any other cycle do not matter.
- R8: With opcode 2'd1 the result is A' + B modulo 2^16. With any other opcode it is A'. A' is the bitwise inverse of operand A when invertAIn was set at issue, and operand A otherwise. For example, 5 inverted plus 2 gives 65532.
- R9: wrRelOut rises in the cycle after the last operand go, or two cycles after issue when no port is read. While wrRelOut is high, no read release is high and resultOut holds the result unchanged. resultOut is 0 while wrRelOut is low.
- R10: A wrGoIn while wrRelOut is high makes busyOut and wrRelOut low in the next cycle, and a new issue is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueIn | input | 1 | Issue strobe, valid only while busyOut is low |
| opcodeIn | input | 2 | Operation select (1 = add, else pass A) |
| invertAIn | input | 1 | Invert operand A before the ALU |
| zeroAIn | input | 1 | Use zero for operand A, skip port 0 |
| immIn | input | 16 | Immediate value for operand B |
| immValidIn | input | 1 | Use immediate for operand B, skip port 1 |
| rdMaskIn | input | 2 | Per-port read suppression, held while busy |
| busyOut | output | 1 | Operation in flight |
| rdRelOut | output | 2 | Per-port operand request |
| rdGoIn | input | 2 | Per-port operand grant |
| srcAIn | input | 16 | Operand data for port 0 |
| srcBIn | input | 16 | Operand data for port 1 |
| wrRelOut | output | 1 | Writeback request |
| wrGoIn | input | 1 | Writeback grant |
| resultOut | output | 16 | Result, valid while wrRelOut is high |

## Verification
Properties checked on every cycle cover the cycle-level handshake rules. Busy rises after an accepted issue and holds until the write grant. Each release holds through stalls, drops after its go and never rises outside an issue. Suppressed ports stay silent, read and write releases never overlap, and the result holds steady while it waits. Only the bench scenarios can show that the arithmetic is right for each mix of zero, immediate, mask and invert. They also show that fields changed after issue, stray issue pulses and stray read grants leave the result untouched, and that back-to-back operations start in the cycle after the write grant.

// File: rtl/aom_pkg.sv
package aom_pkg;
  localparam int RD_PORTS = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } cuState_e;

  typedef struct packed {
    logic                latchOp;
    logic [RD_PORTS-1:0] capOperand;
    logic                latchResult;
  } cuStrobe_t;
endpackage

// File: rtl/aom_alu.sv
module aom_alu #(
  parameter int DATA_W  = 16,
  parameter int OPC_W   = 2,
  parameter int OPC_ADD = 1
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic              invertA,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] effA;

  always_comb begin
    effA = invertA ? ~opA : opA;
    if (opcode == OPC_W'(OPC_ADD)) result = effA + opB;
    else                           result = effA;
  end
endmodule

// File: rtl/aom_ctrl.sv
module aom_ctrl
  import aom_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueIn,
  input  logic                zeroAIn,
  input  logic                immValidIn,
  input  logic [RD_PORTS-1:0] rdMaskIn,
  input  logic [RD_PORTS-1:0] rdGoIn,
  input  logic                wrGoIn,
  output logic                busyOut,
  output logic [RD_PORTS-1:0] rdRelOut,
  output logic                wrRelOut,
  output cuStrobe_t           strb
);
  cuState_e            state;
  logic [RD_PORTS-1:0] pending;
  logic [RD_PORTS-1:0] nextPending;
  logic [RD_PORTS-1:0] suppress;

  always_comb begin
    suppress         = rdMaskIn | {immValidIn, zeroAIn};
    nextPending      = pending & ~rdGoIn;
    strb.latchOp     = (state == ST_IDLE) && issueIn;
    strb.capOperand  = pending & rdGoIn;
    strb.latchResult = (state == ST_READ) && (nextPending == '0);
    busyOut          = (state != ST_IDLE);
    wrRelOut         = (state == ST_WRITE);
    rdRelOut         = pending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (issueIn) begin
          state   <= ST_READ;
          pending <= ~suppress;
        end
        ST_READ: begin
          pending <= nextPending;
          if (nextPending == '0) state <= ST_WRITE;
        end
        ST_WRITE: if (wrGoIn) state <= ST_IDLE;
        default: begin
          state   <= ST_IDLE;
          pending <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/aom_dpath.sv
module aom_dpath
  import aom_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int OPC_W   = 2,
  parameter int OPC_ADD = 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  cuStrobe_t                        strb,
  input  logic [OPC_W-1:0]                 opcodeIn,
  input  logic                             invertAIn,
  input  logic                             zeroAIn,
  input  logic [DATA_W-1:0]                immIn,
  input  logic                             immValidIn,
  input  logic [RD_PORTS-1:0]              rdMaskIn,
  input  logic [RD_PORTS-1:0][DATA_W-1:0]  srcIn,
  input  logic                             wrRelIn,
  output logic [DATA_W-1:0]                resultOut
);
  logic [OPC_W-1:0]    opcodeR;
  logic                invertR, zeroR, immValidR;
  logic [DATA_W-1:0]   immR;
  logic [RD_PORTS-1:0] maskR;
  logic [DATA_W-1:0]   operandR   [RD_PORTS];
  logic [DATA_W-1:0]   operandFwd [RD_PORTS];
  logic [DATA_W-1:0]   aluA, aluB, aluY, resultR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcodeR   <= '0;
      invertR   <= 1'b0;
      zeroR     <= 1'b0;
      immValidR <= 1'b0;
      immR      <= '0;
      maskR     <= '0;
    end else if (strb.latchOp) begin
      opcodeR   <= opcodeIn;
      invertR   <= invertAIn;
      zeroR     <= zeroAIn;
      immValidR <= immValidIn;
      immR      <= immIn;
      maskR     <= rdMaskIn;
    end
  end

  // one capture register per read port, bypassed in the grant cycle
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN)                   operandR[p] <= '0;
      else if (strb.capOperand[p]) operandR[p] <= srcIn[p];
    end
    assign operandFwd[p] = strb.capOperand[p] ? srcIn[p] : operandR[p];
  end

  always_comb begin
    aluA = (zeroR || maskR[0]) ? '0 : operandFwd[0];
    if (immValidR)     aluB = immR;
    else if (maskR[1]) aluB = '0;
    else               aluB = operandFwd[1];
  end

  aom_alu #(.DATA_W(DATA_W), .OPC_W(OPC_W), .OPC_ADD(OPC_ADD)) u_alu (
    .opcode (opcodeR),
    .invertA(invertR),
    .opA    (aluA),
    .opB    (aluB),
    .result (aluY)
  );

  always_ff @(posedge clk) begin
    if (!rstN)                 resultR <= '0;
    else if (strb.latchResult) resultR <= aluY;
  end

  assign resultOut = wrRelIn ? resultR : '0;
endmodule

// File: rtl/alu_op_manager.sv
module alu_op_manager
  import aom_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int OPC_W   = 2,
  parameter int OPC_ADD = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueIn,
  input  logic [OPC_W-1:0]    opcodeIn,
  input  logic                invertAIn,
  input  logic                zeroAIn,
  input  logic [DATA_W-1:0]   immIn,
  input  logic                immValidIn,
  input  logic [RD_PORTS-1:0] rdMaskIn,
  output logic                busyOut,
  output logic [RD_PORTS-1:0] rdRelOut,
  input  logic [RD_PORTS-1:0] rdGoIn,
  input  logic [DATA_W-1:0]   srcAIn,
  input  logic [DATA_W-1:0]   srcBIn,
  output logic                wrRelOut,
  input  logic                wrGoIn,
  output logic [DATA_W-1:0]   resultOut
);
  cuStrobe_t                       strb;
  logic [RD_PORTS-1:0][DATA_W-1:0] srcVec;

  assign srcVec[0] = srcAIn;
  assign srcVec[1] = srcBIn;

  aom_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .issueIn   (issueIn),
    .zeroAIn   (zeroAIn),
    .immValidIn(immValidIn),
    .rdMaskIn  (rdMaskIn),
    .rdGoIn    (rdGoIn),
    .wrGoIn    (wrGoIn),
    .busyOut   (busyOut),
    .rdRelOut  (rdRelOut),
    .wrRelOut  (wrRelOut),
    .strb      (strb)
  );

  aom_dpath #(.DATA_W(DATA_W), .OPC_W(OPC_W), .OPC_ADD(OPC_ADD)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opcodeIn  (opcodeIn),
    .invertAIn (invertAIn),
    .zeroAIn   (zeroAIn),
    .immIn     (immIn),
    .immValidIn(immValidIn),
    .rdMaskIn  (rdMaskIn),
    .srcIn     (srcVec),
    .wrRelIn   (wrRelOut),
    .resultOut (resultOut)
  );
endmodule

// File: rtl/aom_checker.sv
module aom_checker
  import aom_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                issueIn,
  input logic                zeroAIn,
  input logic                immValidIn,
  input logic [RD_PORTS-1:0] rdMaskIn,
  input logic                busyOut,
  input logic [RD_PORTS-1:0] rdRelOut,
  input logic [RD_PORTS-1:0] rdGoIn,
  input logic                wrRelOut,
  input logic                wrGoIn,
  input logic [DATA_W-1:0]   resultOut
);
  // R2
  issue_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueIn && !busyOut) |=> busyOut);
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && !(wrRelOut && wrGoIn)) |=> busyOut);

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rel
    // R4
    rel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (rdRelOut[p] && !rdGoIn[p]) |=> rdRelOut[p]);
    // R5
    rel_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (rdRelOut[p] && rdGoIn[p]) |=> !rdRelOut[p]);
    // R5
    rel_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rdRelOut[p]) |-> $past(issueIn && !busyOut));
  end

  // R6
  port0_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueIn && !busyOut && (zeroAIn || rdMaskIn[0])) |=> !rdRelOut[0]);
  // R6
  port1_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueIn && !busyOut && (immValidIn || rdMaskIn[1])) |=> !rdRelOut[1]);
  // R9
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrRelOut |-> (rdRelOut == '0));
  // R9
  result_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrRelOut && $past(wrRelOut)) |-> $stable(resultOut));
  // R10
  wr_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrRelOut && wrGoIn) |=> (!busyOut && !wrRelOut));
endmodule

bind alu_op_manager aom_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_alu_op_manager.sv
module sim_alu_op_manager;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueIn = 1'b0;
  logic [1:0]  opcodeIn = '0;
  logic        invertAIn = 1'b0, zeroAIn = 1'b0, immValidIn = 1'b0;
  logic [15:0] immIn = '0, srcAIn = '0, srcBIn = '0;
  logic [1:0]  rdMaskIn = '0, rdGoIn = '0;
  logic        wrGoIn = 1'b0;
  logic        busyOut, wrRelOut;
  logic [1:0]  rdRelOut;
  logic [15:0] resultOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  alu_op_manager u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model(input logic [15:0] a, b, imm, input logic [1:0] opc,
                                        input logic inv, zro, iv, input logic [1:0] msk);
    logic [15:0] va, vb;
    va = (zro || msk[0]) ? 16'd0 : a;
    vb = iv ? imm : (msk[1] ? 16'd0 : b);
    if (inv) va = ~va;
    return (opc == 2'd1) ? va + vb : va;
  endfunction

  // entered and left at a negative clock edge
  task automatic runOp(input logic [15:0] a, b, imm, input logic [1:0] opc,
                       input logic inv, zro, iv, input logic [1:0] msk,
                       input int st0, st1, wst, input bit poke);
    logic [1:0]  need, done, drv;
    logic [15:0] exp;
    int cnt;
    exp  = model(a, b, imm, opc, inv, zro, iv, msk);
    need = ~({iv, zro} | msk);
    chk(busyOut == 1'b0, "R10", busyOut, 0);
    issueIn = 1'b1; opcodeIn = opc; invertAIn = inv; zeroAIn = zro;
    immIn = imm; immValidIn = iv; rdMaskIn = msk;
    @(posedge clk); @(negedge clk);
    issueIn = 1'b0;
    // R3: scramble fields after issue
    opcodeIn = 2'($urandom); invertAIn = 1'($urandom); zeroAIn = 1'($urandom);
    immIn = 16'($urandom); immValidIn = 1'($urandom);
    chk(busyOut == 1'b1, "R2", busyOut, 1);
    done = '0; cnt = 0;
    while (1) begin
      // R4 and R5: releases follow outstanding ports exactly
      chk(rdRelOut == (need & ~done), "R4", rdRelOut, need & ~done);
      if (done == need) break;
      chk(wrRelOut == 1'b0, "R9", wrRelOut, 0);
      drv = '0;
      if (need[0] && !done[0] && cnt >= st0) drv[0] = 1'b1;
      if (need[1] && !done[1] && cnt >= st1) drv[1] = 1'b1;
      rdGoIn = drv;
      // R7: operand only on grant cycle
      srcAIn = drv[0] ? a : 16'($urandom);
      srcBIn = drv[1] ? b : 16'($urandom);
      if (poke && cnt == 0) begin
        issueIn = 1'b1; opcodeIn = ~opc; // R2: ignored while busy
      end
      @(posedge clk); @(negedge clk);
      issueIn = 1'b0; rdGoIn = '0;
      srcAIn = 16'($urandom); srcBIn = 16'($urandom);
      done |= drv; cnt++;
    end
    if (need == 2'b00) begin
      chk(wrRelOut == 1'b0, "R9", wrRelOut, 0);
      @(posedge clk); @(negedge clk);
    end
    chk(wrRelOut == 1'b1, "R9", wrRelOut, 1);
    chk(resultOut == exp, "R8", resultOut, exp);
    for (int w = 0; w < wst; w++) begin
      rdGoIn = 2'b11; // R5: stray grants ignored
      @(posedge clk); @(negedge clk);
      rdGoIn = '0;
      chk(rdRelOut == 2'b00, "R5", rdRelOut, 0);
      chk(busyOut && wrRelOut, "R9", {busyOut, wrRelOut}, 3);
      chk(resultOut == exp, "R9", resultOut, exp);
    end
    wrGoIn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrGoIn = 1'b0;
    chk(busyOut == 1'b0 && wrRelOut == 1'b0, "R10", {busyOut, wrRelOut}, 0);
    chk(resultOut == 16'd0, "R9", resultOut, 0);
    rdMaskIn = '0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(busyOut == 0 && rdRelOut == 0 && wrRelOut == 0 && resultOut == 0, "R1",
        {busyOut, rdRelOut, wrRelOut}, 0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(busyOut == 0 && rdRelOut == 0 && wrRelOut == 0 && resultOut == 0, "R1",
        {busyOut, rdRelOut, wrRelOut}, 0);
    // directed corners
    runOp(5, 2, 8, 2'd1, 0, 0, 1, 2'b00, 0, 0, 0, 0); // R6 immediate -> 13
    runOp(5, 2, 8, 2'd1, 0, 0, 0, 2'b00, 0, 3, 1, 0); // R4 stall -> 7
    runOp(5, 2, 0, 2'd1, 1, 0, 0, 2'b00, 2, 0, 0, 0); // R8 invert -> 65532
    runOp(5, 2, 8, 2'd1, 0, 1, 1, 2'b00, 0, 0, 0, 0); // R6 no reads -> 8
    runOp(5, 2, 8, 2'd1, 0, 1, 0, 2'b00, 0, 1, 2, 1); // R6 zero A -> 2, R2 poke
    runOp(5, 2, 8, 2'd1, 0, 0, 0, 2'b01, 0, 0, 0, 0); // R6 mask port 0 -> 2
    runOp(5, 2, 8, 2'd1, 0, 0, 0, 2'b10, 3, 0, 0, 0); // R6 mask port 1 -> 5
    runOp(9, 2, 8, 2'd0, 0, 0, 0, 2'b00, 1, 1, 0, 1); // R8 pass A -> 9
    runOp(16'hFFFF, 1, 0, 2'd1, 0, 0, 0, 2'b00, 0, 0, 0, 0); // R8 wrap -> 0
    for (int i = 0; i < 60; i++) begin
      logic [1:0] m;
      m = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      runOp(16'($urandom), 16'($urandom), 16'($urandom), 2'($urandom),
            1'($urandom), ($urandom % 4 == 0), ($urandom % 3 == 0), m,
            $urandom % 4, $urandom % 4, $urandom % 3, ($urandom % 5 == 0));
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule